// File: doc/BRIEF.md
# Hub Slot Arbiter with Donation

The block shares one memory port among N cores by time division. A slot counter steps through the cores one per clock cycle and wraps after the last one. The core whose index equals the counter owns the current slot. With every option clear, the arbiter is a strict round-robin: the owner is granted when it requests, and the slot is otherwise unused.

Two per-core options relax this rotation on purpose. A core may donate its slot to a chosen recipient. In fill-in form the recipient only gets the slot when the donor is idle. In give-away form the recipient takes the slot even when the donor is requesting. A core may also be made opportunistic. It then picks up slots that would otherwise go unused, and a slot left by a donor counts as one of those. When several opportunistic cores want the same idle slot, the first requester after the owner in rotating order wins. A directed recipient always beats opportunistic claimants.

The grant is combinational from the registered slot counter and the present inputs, so a request is granted in the same cycle in which its slot comes up. The block has one state register, the slot counter. Each cycle's grant decision takes one of five named sources: NONE, GIFT (give-away recipient), OWNER, FILL (fill-in recipient) and SPARE (opportunistic claimant). The decision is a fixed priority in that order: GIFT, OWNER, FILL, SPARE, NONE.

Top module: `hub_slot_arbiter`

## Requirements
- R1: While rst_n is low, grant is all zero and slot_owner is 0. In the first cycle after reset is released, slot_owner is 0.
- R2: slot_owner advances by one every clock cycle and wraps from N-1 to 0.
- R3: When donate_en and opport_en are clear for every core, grant equals the owner's one-hot bit if the owner requests, and is zero otherwise. donate_pri and donate_to have no effect. A core that requests continuously is granted exactly once in every N cycles.
- R4: At most one grant bit is set in any cycle. A grant bit is set only for a core whose req bit is high. When no core requests, grant is zero.
- R5: Fill-in donation (donate_en=1, donate_pri=0 on the owner): a requesting owner keeps its slot. An idle owner's slot goes to the core named by its donate_to field, if that core requests.
- R6: Give-away donation (donate_en=1, donate_pri=1 on the owner): the recipient named by donate_to is granted whenever it requests, even when the owner requests. If the recipient is idle, a requesting owner is granted.
- R7: An opportunistic core is never granted a slot whose owner requests and has not set give-away donation.
- R8: When the owner is idle and no directed recipient is requesting, the slot goes to a requesting core with opport_en set. Among several such cores, the winner is the first one found after the owner, counting upward with wrap.
- R9: A requesting directed recipient takes the donor's slot ahead of any opportunistic claimant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N_CORES | Per-core access request |
| donate_en | input | N_CORES | Per-core slot donation enable |
| donate_pri | input | N_CORES | Per-core donation form: 1 = give-away, 0 = fill-in |
| donate_to | input | N_CORES*ID_W | Per-core recipient index; core c uses bits [c*ID_W +: ID_W] |
| opport_en | input | N_CORES | Per-core opportunistic claiming enable |
| grant | output | N_CORES | One-hot grant for the current cycle |
| slot_owner | output | ID_W | Index of the core owning the current slot |

## Verification
The bench aims at the cases where the priority order matters:
- **Give-away with both parties requesting.** A design that mixed up the two donation forms would hand this slot to the owner.
- **Fill-in with the owner busy.** Such a design would wrongly pass this slot to the recipient.
- **Busy, non-donating owner with opportunistic cores waiting.** A broken protection check would let a claimant steal the slot, which breaks determinism.
- **Several opportunistic claimants on slots at different rotation offsets.** A fixed-priority picker, instead of one that starts after the owner, would pick the wrong core.
- **Recipient and claimant both requesting a donated slot.** This exposes a reversed precedence.

A long pseudo-random run then mixes all the options. A further check confirms that a core requesting continuously with all options clear is granted once every N cycles. This catches a counter that skips or repeats a slot.

// File: rtl/hsa_pkg.sv
package hsa_pkg;
    typedef enum logic [2:0] {
        SRC_NONE  = 3'd0,
        SRC_GIFT  = 3'd1,
        SRC_OWNER = 3'd2,
        SRC_FILL  = 3'd3,
        SRC_SPARE = 3'd4
    } grant_src_e;
endpackage

// File: rtl/hsa_slot_counter.sv
module hsa_slot_counter #(
    parameter int N_CORES = 4,
    localparam int ID_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [ID_W-1:0] slot_q
);
    localparam logic [ID_W-1:0] LAST = ID_W'(N_CORES - 1);

    always_ff @(posedge clk) begin
        if (!rst_n)
            slot_q <= '0;
        else if (slot_q == LAST)
            slot_q <= '0;
        else
            slot_q <= slot_q + 1'b1;
    end

    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == LAST) |=> (slot_q == '0)); // R2
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q != LAST) |=> (slot_q == $past(slot_q) + 1'b1)); // R2
endmodule

// File: rtl/hsa_spare_pick.sv
module hsa_spare_pick #(
    parameter int N_CORES = 4,
    localparam int ID_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ID_W-1:0]    slot,
    input  logic [N_CORES-1:0] cand,
    output logic               found,
    output logic [ID_W-1:0]    pick
);
    // Scan from the farthest offset down to the nearest, so that the
    // core nearest after the owner is the one left in pick.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = N_CORES - 1; k >= 1; k--) begin
            int s;
            s = int'(slot) + k;
            if (s >= N_CORES) s = s - N_CORES;
            if (cand[s]) begin
                found = 1'b1;
                pick  = ID_W'(s);
            end
        end
    end

    AST_PICK_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (cand[pick] && (pick != slot))); // R8
    AST_PICK_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        ((cand & ~(N_CORES'(1) << slot)) != '0) |-> found); // R8
endmodule

// File: rtl/hsa_src_decide.sv
module hsa_src_decide
    import hsa_pkg::*;
#(
    parameter int N_CORES = 4,
    localparam int ID_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic                    slot_req,
    input  logic                    slot_den,
    input  logic                    slot_dpri,
    input  logic [ID_W-1:0]         slot_dto,
    input  logic [N_CORES-1:0]      req,
    input  logic                    spare_found,
    output grant_src_e              src,
    output logic [ID_W-1:0]         recip
);
    logic recip_req;

    always_comb begin
        recip     = slot_dto;
        recip_req = (int'(slot_dto) < N_CORES) ? req[slot_dto] : 1'b0;
        if (slot_den && slot_dpri && recip_req)
            src = SRC_GIFT;
        else if (slot_req)
            src = SRC_OWNER;
        else if (slot_den && recip_req)
            src = SRC_FILL;
        else if (spare_found)
            src = SRC_SPARE;
        else
            src = SRC_NONE;
    end
endmodule

// File: rtl/hub_slot_arbiter.sv
module hub_slot_arbiter
    import hsa_pkg::*;
#(
    parameter int N_CORES = 4,
    localparam int ID_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_CORES-1:0]        req,
    input  logic [N_CORES-1:0]        donate_en,
    input  logic [N_CORES-1:0]        donate_pri,
    input  logic [N_CORES*ID_W-1:0]   donate_to,
    input  logic [N_CORES-1:0]        opport_en,
    output logic [N_CORES-1:0]        grant,
    output logic [ID_W-1:0]           slot_owner
);
    logic [ID_W-1:0]    slot_q;
    logic [ID_W-1:0]    owner_dto;
    logic [ID_W-1:0]    recip;
    logic [ID_W-1:0]    spare_idx;
    logic               spare_found;
    grant_src_e         src;

    hsa_slot_counter #(.N_CORES(N_CORES)) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .slot_q (slot_q)
    );

    assign owner_dto = donate_to[int'(slot_q)*ID_W +: ID_W];

    hsa_spare_pick #(.N_CORES(N_CORES)) u_spare (
        .clk   (clk),
        .rst_n (rst_n),
        .slot  (slot_q),
        .cand  (req & opport_en),
        .found (spare_found),
        .pick  (spare_idx)
    );

    hsa_src_decide #(.N_CORES(N_CORES)) u_decide (
        .slot_req    (req[slot_q]),
        .slot_den    (donate_en[slot_q]),
        .slot_dpri   (donate_pri[slot_q]),
        .slot_dto    (owner_dto),
        .req         (req),
        .spare_found (spare_found),
        .src         (src),
        .recip       (recip)
    );

    // Output process: one-hot grant from the decided source.
    always_comb begin
        grant = '0;
        if (rst_n) begin
            unique case (src)
                SRC_GIFT, SRC_FILL: grant[recip]     = 1'b1;
                SRC_OWNER:          grant[slot_q]    = 1'b1;
                SRC_SPARE:          grant[spare_idx] = 1'b1;
                SRC_NONE:           grant            = '0;
                default:            grant            = '0;
            endcase
        end
    end

    assign slot_owner = slot_q;

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R4
    AST_GRANT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & ~req) == '0)); // R4
    AST_OWNER_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (req[slot_q] && !(donate_en[slot_q] && donate_pri[slot_q])) |-> grant[slot_q]); // R7
    AST_GIFT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (donate_en[slot_q] && donate_pri[slot_q] && (int'(owner_dto) < N_CORES)
         && req[owner_dto]) |-> grant[owner_dto]); // R6
    AST_FILL_USES: assert property (@(posedge clk) disable iff (!rst_n)
        (donate_en[slot_q] && !req[slot_q] && (int'(owner_dto) < N_CORES)
         && req[owner_dto]) |-> grant[owner_dto]); // R9
endmodule

// File: tb/test_hub_slot_arbiter.sv
`timescale 1ns/1ps
module test_hub_slot_arbiter;
    localparam int N    = 4;
    localparam int IDW  = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req = '0;
    logic [N-1:0]    den = '0;
    logic [N-1:0]    dpri = '0;
    logic [N*IDW-1:0] dto = '0;
    logic [N-1:0]    opp = '0;
    logic [N-1:0]    grant;
    logic [IDW-1:0]  slot_owner;

    hub_slot_arbiter #(.N_CORES(N)) i_hub_slot_arbiter (
        .clk(clk), .rst_n(rst_n), .req(req), .donate_en(den),
        .donate_pri(dpri), .donate_to(dto), .opport_en(opp),
        .grant(grant), .slot_owner(slot_owner)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [N-1:0]   g;
        logic [IDW-1:0] o;
        string          tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    int bench_slot = 0;
    bit cnt_on = 0;
    bit done = 0;
    int gcnt[N];

    function automatic logic [N-1:0] model(int s);
        int r;
        r = int'(dto[s*IDW +: IDW]);
        if (den[s] && dpri[s] && req[r]) return N'(1) << r;
        if (req[s]) return N'(1) << s;
        if (den[s] && req[r]) return N'(1) << r;
        for (int k = 1; k < N; k++) begin
            int c;
            c = (s + k) % N;
            if (opp[c] && req[c]) return N'(1) << c;
        end
        return '0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
    endtask

    // Driver: called at a falling edge; drives, queues expectation, steps a cycle.
    task automatic step(input logic [N-1:0] rq, input string tag);
        exp_t e;
        req = rq;
        e.g = model(bench_slot);
        e.o = IDW'(bench_slot);
        e.tag = tag;
        q.push_back(e);
        @(posedge clk);
        bench_slot = (bench_slot + 1) % N;
        @(negedge clk);
    endtask

    task automatic set_dto(input int c, input int r);
        dto[c*IDW +: IDW] = IDW'(r);
    endtask

    // Monitor: samples mid-low-phase and compares against the queue.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check({e.tag, " grant"}, 32'(grant), 32'(e.g));
                check("R2 slot_owner", 32'(slot_owner), 32'(e.o));
                if (cnt_on)
                    for (int c = 0; c < N; c++) if (grant[c]) gcnt[c]++;
            end
        end
    end

    initial begin
        #(64'd20 * 64'd200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] lf;
        // R1: reset state with requests present
        req = '1;
        repeat (3) @(posedge clk);
        #5;
        check("R1 grant in reset", 32'(grant), 0);
        check("R1 owner in reset", 32'(slot_owner), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 owner after release", 32'(slot_owner), 0);

        // R3: continuous requests, all options off, once per N cycles each
        for (int c = 0; c < N; c++) gcnt[c] = 0;
        cnt_on = 1;
        repeat (2 * N) step('1, "R3 all request");
        cnt_on = 0;
        for (int c = 0; c < N; c++) check("R3 grants per 2N cycles", 32'(gcnt[c]), 2);

        // R3: donate_pri / donate_to ignored while donate_en clear
        dpri = '1;
        for (int c = 0; c < N; c++) set_dto(c, (c + 1) % N);
        repeat (N) step(4'b0101, "R3 options ignored");
        repeat (N) step(4'b1010, "R3 sparse");
        dpri = '0;

        // R4: nobody requests
        opp = '1;
        repeat (N) step('0, "R4 idle");
        opp = '0;

        // R5: fill-in, core1 -> core3
        den = 4'b0010; set_dto(1, 3);
        repeat (N) step(4'b1010, "R5 owner busy keeps");
        repeat (N) step(4'b1000, "R5 idle owner fills");

        // R6: give-away, core2 -> core0
        den = 4'b0100; dpri = 4'b0100; set_dto(2, 0);
        repeat (N) step(4'b0101, "R6 recipient takes");
        repeat (N) step(4'b0100, "R6 recipient idle owner keeps");
        den = '0; dpri = '0;

        // R7 / R8: opportunistic
        opp = 4'b1100;
        repeat (N) step(4'b1111, "R7 owners protected");
        repeat (N) step(4'b1100, "R8 rotating claim");
        opp = 4'b1011;
        repeat (N) step(4'b1011, "R8 claim mix");
        repeat (N) step(4'b0001, "R8 single claimant");

        // R9: recipient beats opportunistic
        opp = 4'b0100; den = 4'b0001; set_dto(0, 1);
        repeat (N) step(4'b0110, "R9 recipient first");
        dpri = 4'b0001;
        repeat (N) step(4'b0111, "R9 gift first");
        den = '0; dpri = '0; opp = '0;

        // Mixed pseudo-random options
        lf = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            den  = lf[3:0] & lf[7:4];
            dpri = lf[11:8];
            dto  = {lf[5:0], lf[15:14]};
            opp  = lf[15:12] ^ lf[2:0];
            step(lf[9:6] ^ lf[1:0], "R4 mixed");
        end

        @(negedge clk);
        summary();
        $finish;
    end
endmodule